// File: doc/BRIEF.md
# Streaming Varint Decoder

This block turns a stream of protocol-buffer variable-length integers into 64-bit values. It takes in one byte per clock, at the byte rate of the link that feeds it, for example a gigabit Ethernet receive path. Each byte carries seven payload bits and one flag bit that says whether more bytes follow. The block collects the payload groups of a value as they arrive. When the final byte lands, it merges the stored groups with that byte in combinational logic. The merged value goes into a single output register, so the result is ready one clock after the last byte.

A mode input selects one of two readings of the merged value. Unsigned mode passes it through unchanged. Signed mode undoes the sign folding, in which the sign travels in bit 0. Cycles without the valid flag leave the block untouched, so the stream may stall at any point, even in the middle of a value. A value that is still not finished after ten bytes is thrown away and reported on an error strobe.

Top module: `varint_stream_decoder`

## Requirements
- R1: While reset is low, and in the first cycle after it, `out_done`, `out_error` and `out_value` are all zero.
- R2: A valid byte with bit 7 clear ends a value. One clock after that byte is sampled, `out_done` is 1 for one cycle. A single-byte value decodes to bits 6:0 of that byte.
- R3: Each byte adds its bits 6:0 as the next group, lowest group first: byte k fills value bits 7k+6 down to 7k. A set bit 7 means another byte follows.
- R4: `in_signed` is sampled with the terminating byte. If it is 1, the output is (raw >> 1) XOR (0 − raw[0]). If it is 0, the output is raw.
- R5: `out_done` and `out_error` never assert in the same cycle. `out_value` keeps its value in every cycle where `out_done` is 0.
- R6: If the tenth byte of a value is valid with bit 7 set, `out_error` pulses for one cycle, `out_done` stays 0, and the next valid byte starts a new value.
- R7: A ten-byte value uses only bit 0 of its tenth byte, which becomes value bit 63. Bits 6:1 of that byte are discarded.
- R8: A cycle with `in_valid` low changes nothing, whatever is on `in_byte` and `in_signed`. A value interrupted by such cycles decodes exactly as it would without them.
- R9: Values may follow one another with no idle cycles. Each terminating byte then yields its own result one clock later, even when `out_done` is high in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per stream byte |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Qualifies `in_byte` and `in_signed` |
| in_byte | input | 8 | Stream byte: bit 7 continuation, bits 6:0 payload |
| in_signed | input | 1 | 1 selects sign-folded decoding for the value that ends with this byte |
| out_done | output | 1 | One-cycle strobe: a value has completed |
| out_value | output | 64 | Last decoded value |
| out_error | output | 1 | One-cycle strobe: a value exceeded ten bytes |

## Verification
Two events can share a cycle. A terminating byte can be merged and sent out while the count returns to zero for the next value, and that next value's first byte can arrive in the very next cycle. When that byte is itself a terminator, `out_done` stays high for two cycles in a row. The bench provokes this with gap-free streams of short and long values, and with valid input following directly after an overflow. It judges every result against a reference encoder and decoder written in the bench, and it checks that no value leaks groups into the one that follows.

// File: rtl/varint_pkg.sv
// Package: shared constants and the decode-mode encoding for the varint decoder.
// Assumes: a byte is one continuation flag on top of GRP_W payload bits.
package varint_pkg;

    // payload bits carried by each stream byte
    localparam int VARINT_GRP_W = 7;

    // decoded-value width used by default
    localparam int VARINT_VAL_W = 64;

    // interpretation applied to the raw merged value
    typedef enum logic {
        VMODE_PLAIN  = 1'b0,
        VMODE_FOLDED = 1'b1
    } vmode_e;

endpackage

// File: rtl/varint_accum.sv
// Module: varint_accum
// Holds the payload groups of the value being received, together with the
// count of groups stored so far. A group is stored only when it is followed by
// a continuation. A terminating or overflowing byte sends the count back to
// zero. Stale groups need no clearing, because the merge masks them by count.
// Assumes: the last slot (MAX_BYTES-1) is never stored, since it is always the
// final byte or an overflow.
module varint_accum #(
    parameter int MAX_BYTES = 10,
    parameter int GRP_W     = 7,
    parameter int CNT_W     = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             in_valid,
    input  logic                             in_cont,
    input  logic [GRP_W-1:0]                 in_grp,
    output logic [CNT_W-1:0]                 cnt,
    output logic [(MAX_BYTES-1)*GRP_W-1:0]   grp_flat,
    output logic                             last_slot
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(MAX_BYTES - 1);

    // flags the byte position that can only end or overflow a value
    always_comb last_slot = (cnt == LAST_IDX);

    // advances the group count, or restarts it on a terminator or overflow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (in_valid) begin
            if (!in_cont || last_slot) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < MAX_BYTES - 1; gi++) begin : g_slot
            // captures one group when its position is the current count
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    grp_flat[gi*GRP_W +: GRP_W] <= '0;
                end else if (in_valid && in_cont && (cnt == CNT_W'(gi))) begin
                    grp_flat[gi*GRP_W +: GRP_W] <= in_grp;
                end
            end
        end
    endgenerate

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(cnt));

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST_IDX);

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_cont && !last_slot) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/varint_merge.sv
// Module: varint_merge
// Combinational merge of the stored groups with the byte that arrives now.
// Slot i fills bits starting at i*GRP_W. Slots below the count take stored
// groups, the slot at the count takes the incoming byte, and higher slots are zero.
// Assumes: slots past VAL_W are truncated, so the top slot may be narrower.
module varint_merge #(
    parameter int MAX_BYTES = 10,
    parameter int GRP_W     = 7,
    parameter int VAL_W     = 64,
    parameter int CNT_W     = 4
) (
    input  logic [CNT_W-1:0]                 cnt,
    input  logic [(MAX_BYTES-1)*GRP_W-1:0]   grp_flat,
    input  logic [GRP_W-1:0]                 cur_grp,
    output logic [VAL_W-1:0]                 raw
);

    genvar si;
    generate
        for (si = 0; si < MAX_BYTES; si++) begin : g_pos
            localparam int LO   = si * GRP_W;
            localparam int REM  = VAL_W - LO;
            localparam int W_I  = (REM < GRP_W) ? REM : GRP_W;
            if (si < MAX_BYTES - 1) begin : g_stored
                // picks the stored group, the current byte, or zero for this slot
                always_comb begin
                    if (CNT_W'(si) < cnt) begin
                        raw[LO +: W_I] = grp_flat[LO +: W_I];
                    end else if (CNT_W'(si) == cnt) begin
                        raw[LO +: W_I] = cur_grp[W_I-1:0];
                    end else begin
                        raw[LO +: W_I] = '0;
                    end
                end
            end else begin : g_top
                // the top slot is only ever filled from the current byte
                always_comb begin
                    if (CNT_W'(si) == cnt) begin
                        raw[LO +: W_I] = cur_grp[W_I-1:0];
                    end else begin
                        raw[LO +: W_I] = '0;
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/varint_unfold.sv
// Module: varint_unfold
// Applies the selected interpretation to the raw merged value. Folded mode
// moves the sign out of bit 0 and restores two's complement. Plain mode passes
// the value through.
// Assumes: purely combinational, with mode taken alongside the terminating byte.
module varint_unfold
    import varint_pkg::*;
#(
    parameter int VAL_W = 64
) (
    input  logic [VAL_W-1:0] raw,
    input  vmode_e           mode,
    output logic [VAL_W-1:0] val
);

    // selects the pass-through or the sign-restored value
    always_comb begin
        if (mode == VMODE_FOLDED) begin
            val = (raw >> 1) ^ {VAL_W{raw[0]}};
        end else begin
            val = raw;
        end
    end

endmodule

// File: rtl/varint_stream_decoder.sv
// Module: varint_stream_decoder (top)
// Accepts one stream byte per clock and decodes variable-length integers.
// The combinational merge and unfold feed a single output register, so a result
// shows one clock after its terminating byte. out_done and out_error are
// one-cycle strobes.
// Assumes: in_signed matters only on the terminating byte, and idle cycles
// (in_valid low) are fully ignored.
module varint_stream_decoder
    import varint_pkg::*;
#(
    parameter int VAL_W = VARINT_VAL_W,
    parameter int GRP_W = VARINT_GRP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [GRP_W:0]     in_byte,
    input  logic               in_signed,
    output logic               out_done,
    output logic [VAL_W-1:0]   out_value,
    output logic               out_error
);

    localparam int MAX_BYTES = (VAL_W + GRP_W - 1) / GRP_W;
    localparam int CNT_W     = $clog2(MAX_BYTES);
    localparam int BYTE_W    = GRP_W + 1;

    logic                           cont;
    logic [GRP_W-1:0]               cur_grp;
    logic [CNT_W-1:0]               cnt;
    logic [(MAX_BYTES-1)*GRP_W-1:0] grp_flat;
    logic                           last_slot;
    logic [VAL_W-1:0]               raw;
    logic [VAL_W-1:0]               decoded;
    logic                           finish;
    logic                           overflow;
    vmode_e                         mode;

    // splits the byte into its flag and payload and picks the mode
    always_comb begin
        cont     = in_byte[BYTE_W-1];
        cur_grp  = in_byte[GRP_W-1:0];
        mode     = in_signed ? VMODE_FOLDED : VMODE_PLAIN;
        finish   = in_valid && !cont;
        overflow = in_valid && cont && last_slot;
    end

    varint_accum #(
        .MAX_BYTES (MAX_BYTES),
        .GRP_W     (GRP_W),
        .CNT_W     (CNT_W)
    ) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_cont   (cont),
        .in_grp    (cur_grp),
        .cnt       (cnt),
        .grp_flat  (grp_flat),
        .last_slot (last_slot)
    );

    varint_merge #(
        .MAX_BYTES (MAX_BYTES),
        .GRP_W     (GRP_W),
        .VAL_W     (VAL_W),
        .CNT_W     (CNT_W)
    ) u_merge (
        .cnt       (cnt),
        .grp_flat  (grp_flat),
        .cur_grp   (cur_grp),
        .raw       (raw)
    );

    varint_unfold #(
        .VAL_W (VAL_W)
    ) u_unfold (
        .raw   (raw),
        .mode  (mode),
        .val   (decoded)
    );

    // registers the strobes and captures a finished value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_done  <= 1'b0;
            out_error <= 1'b0;
            out_value <= '0;
        end else begin
            out_done  <= finish;
            out_error <= overflow;
            if (finish) begin
                out_value <= decoded;
            end
        end
    end

    // R5
    done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_done && out_error));

    // R2
    done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> $past(in_valid && !in_byte[BYTE_W-1]));

    // R6
    err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_error |-> $past(in_valid && in_byte[BYTE_W-1]));

    // R5
    value_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_done |-> $stable(out_value));

    // R4
    sign_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_done && $past(in_signed)) |-> (out_value[VAL_W-1] == $past(raw[0])));

endmodule

// File: tb/varint_stream_decoder_tb.sv
// Bench: directed corner cases plus seeded random values, with results
// compared against an encoder and decoder written in the bench.
module varint_stream_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [7:0]  in_byte;
    logic        in_signed;
    logic        out_done;
    logic [63:0] out_value;
    logic        out_error;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    logic [7:0] eb [10];
    int         en;

    always #5 clk = ~clk;

    varint_stream_decoder u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .in_signed (in_signed),
        .out_done  (out_done),
        .out_value (out_value),
        .out_error (out_error)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] fold(input logic [63:0] v);
        return (v << 1) ^ {64{v[63]}};
    endfunction

    task automatic encode(input logic [63:0] raw);
        logic [63:0] r;
        r  = raw;
        en = 0;
        do begin
            eb[en] = {1'b0, r[6:0]};
            r = r >> 7;
            if (r != 0) eb[en][7] = 1'b1;
            en++;
        end while (r != 0);
    endtask

    // drive at the falling edge, let one rising edge pass, return at the next falling edge
    task automatic step(input logic v, input logic [7:0] b, input logic s);
        in_valid  = v;
        in_byte   = b;
        in_signed = s;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic gaps(input int n, input string req);
        logic [63:0] held;
        for (int k = 0; k < n; k++) begin
            held = out_value;
            step(1'b0, 8'($urandom), 1'($urandom));
            chk(!out_done && !out_error && out_value == held, req, out_value, held);
        end
    endtask

    task automatic send(input logic [63:0] v, input logic sgn, input bit with_gaps, input string req);
        logic [63:0] raw;
        raw = sgn ? fold(v) : v;
        encode(raw);
        for (int i = 0; i < en; i++) begin
            if (with_gaps) gaps(int'($urandom % 3), "R8 idle cycle");
            if (i < en - 1) begin
                step(1'b1, eb[i], 1'($urandom));
                chk(!out_done && !out_error, {req, " no early strobe"}, {62'd0, out_done, out_error}, 64'd0);
            end else begin
                step(1'b1, eb[i], sgn);
                chk(out_done && !out_error, {req, " done strobe"}, {62'd0, out_done, out_error}, 64'd2);
                chk(out_value == v, {req, " value"}, out_value, v);
            end
        end
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        logic [63:0] held;
        void'($urandom(32'd20240607));
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_byte = 8'h00;
        in_signed = 1'b0;
        @(negedge clk);
        step(1'b1, 8'h05, 1'b0);
        step(1'b0, 8'h00, 1'b0);
        // R1 reset state
        chk(!out_done && !out_error && out_value == 0, "R1 in reset", out_value, 64'd0);
        rst_n = 1'b1;
        step(1'b0, 8'h00, 1'b0);
        chk(!out_done && !out_error && out_value == 0, "R1 after reset", out_value, 64'd0);

        // R2 single-byte values
        send(64'h00, 1'b0, 0, "R2 zero");
        send(64'h7F, 1'b0, 0, "R2 max single");
        send(64'h05, 1'b0, 1, "R2 five");

        // R5 strobe is one cycle, value holds
        held = out_value;
        step(1'b0, 8'hFF, 1'b1);
        chk(!out_done && out_value == held, "R5 strobe drop and hold", out_value, held);

        // R3 multi-byte ordering
        send(64'd300, 1'b0, 0, "R3 two bytes");
        send(64'h0123456789ABCDEF, 1'b0, 1, "R3 long");
        send(64'hFFFFFFFFFFFFFFFF, 1'b0, 0, "R3 all ones ten bytes");

        // R4 sign folding
        send(64'hFFFFFFFFFFFFFFFF, 1'b1, 0, "R4 minus one");
        send(64'd1, 1'b1, 0, "R4 plus one");
        send(64'h8000000000000000, 1'b1, 0, "R4 most negative");
        send(64'h7FFFFFFFFFFFFFFF, 1'b1, 1, "R4 most positive");
        step(1'b1, 8'h03, 1'b0);
        chk(out_done && out_value == 64'd3, "R4 plain mode keeps raw", out_value, 64'd3);

        // R6 overflow on the tenth byte
        for (int i = 0; i < 9; i++) begin
            step(1'b1, 8'hFF, 1'b0);
        end
        chk(!out_done && !out_error, "R6 before tenth", {62'd0, out_done, out_error}, 64'd0);
        step(1'b1, 8'hFF, 1'b0);
        chk(out_error && !out_done, "R6 error strobe", {62'd0, out_done, out_error}, 64'd1);
        step(1'b1, 8'h05, 1'b0);
        chk(!out_error && out_done && out_value == 64'd5, "R6 restart after overflow", out_value, 64'd5);

        // R7 tenth byte truncation
        for (int i = 0; i < 9; i++) step(1'b1, 8'h80, 1'b0);
        step(1'b1, 8'h7F, 1'b0);
        chk(out_done && out_value == 64'h8000000000000000, "R7 bit 63 only", out_value, 64'h8000000000000000);
        for (int i = 0; i < 9; i++) step(1'b1, 8'h80, 1'b0);
        step(1'b1, 8'h7E, 1'b0);
        chk(out_done && out_value == 64'd0, "R7 upper bits dropped", out_value, 64'd0);

        // R9 back-to-back with no idle cycles
        step(1'b1, 8'h11, 1'b0);
        chk(out_done && out_value == 64'h11, "R9 first", out_value, 64'h11);
        step(1'b1, 8'h22, 1'b0);
        chk(out_done && out_value == 64'h22, "R9 second", out_value, 64'h22);
        send(64'd300, 1'b0, 0, "R9 long after short");
        send(64'd7, 1'b1, 0, "R9 signed after long");

        // random mix, R8 gaps inside values
        for (int n = 0; n < 400; n++) begin
            v = {32'($urandom), 32'($urandom)} >> ($urandom % 64);
            if ($urandom % 2 == 1) begin
                if ($urandom % 2 == 1) v = ~v;
                send(v, 1'b1, ($urandom % 2) == 1, "R8 random signed");
            end else begin
                send(v, 1'b0, ($urandom % 2) == 1, "R8 random plain");
            end
        end

        ended = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule